// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block produces the pixel stream that a progressive-scan monochrome image sensor would emit, driven from a single master clock. It scans a pixel array that carries an optically black border. The border is wider on the left and top than on the right and bottom. The block drives a frame-valid strobe, a line-valid strobe and a pixel data bus. Between lines it inserts a programmable horizontal gap, and between frames a programmable vertical gap. Each pixel value comes from a fixed arithmetic pattern of its array row and column, so a receiver or a bench can predict every word.

Two output shapes are available. In window mode a rectangle of chosen size and origin is read out. In raw mode the whole array, border included, is read out from the origin. Window, blanking and mode settings arrive on plain input ports. They are captured as a frame finishes, so a frame already in progress is never disturbed. A pixel clock that follows the master clock is provided for the receiver, which samples data on its falling edge.

Top module: `sensor_readout_gen`

## Requirements
- R1: While reset is high, frame_valid, line_valid and pix_data are all zero. The configuration inputs are captured during reset. The first pixel of the first frame appears on the outputs one clock after reset is released.
- R2: In window mode (raw_mode = 0) a frame is win_rows lines of win_cols pixels each, read in row-major order from array column col_start and array row row_start. One pixel is presented per clock while line_valid is high. Frame_valid is high from the first pixel of the frame to its last pixel. Line_valid is never high while frame_valid is low.
- R3: A pixel at array coordinate (row, col) outputs (row*7 + col) modulo 2^DATA_W (1024 by default). A pixel inside the black border outputs the pedestal value 42 instead. The border covers col < BLACK_LEFT, col >= ARRAY_COLS - BLACK_RIGHT, row < BLACK_TOP and row >= ARRAY_ROWS - BLACK_BOTTOM, which by default means 16 left, 7 right, 8 top and 7 bottom.
- R4: Whenever line_valid is low, pix_data is zero.
- R5: Between consecutive lines of a frame, line_valid stays low for max(hblank, 1) clocks while frame_valid stays high.
- R6: Between the last pixel of a frame and the first pixel of the next, frame_valid stays low for H + vblank*(P + H) clocks. Here H = max(hblank, 1) and P is the number of pixels per line of the next frame.
- R7: In raw mode (raw_mode = 1) a frame covers the whole ARRAY_COLS by ARRAY_ROWS array starting at (0,0). The window inputs are ignored.
- R8: The configuration is captured at the clock edge that presents the last pixel of a frame. Input changes at any other time leave the current frame unchanged. The captured values govern the following vertical gap and the next frame.
- R9: pix_clk is high while the master clock is high and low while it is low, including during blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_mode | input | 1 | 1 selects the full array including the black border |
| win_cols | input | COL_W | Pixels per line in window mode |
| win_rows | input | ROW_W | Lines per frame in window mode |
| col_start | input | COL_W | Array column of the window's first pixel |
| row_start | input | ROW_W | Array row of the window's first line |
| hblank | input | HB_W | Horizontal gap in clocks (0 treated as 1) |
| vblank | input | VB_W | Vertical gap in line periods |
| pix_clk | output | 1 | Pixel clock, in phase with clk |
| frame_valid | output | 1 | High across one frame's pixels |
| line_valid | output | 1 | High while a pixel is presented |
| pix_data | output | DATA_W | Pixel value, zero during blanking |

## Verification
The bench builds the block over a 12 by 10 array with border widths of 3 left, 2 top, 2 right and 1 bottom, and 4-bit configuration ports. At that size every pixel of every frame is compared against the arithmetic pattern: window mode, raw mode and a window that straddles the left and bottom border. Every gap is timed to the clock. A new configuration is applied in the middle of each frame, which exposes both premature capture and the use of the captured set for the next vertical gap. A zero horizontal gap exercises the clamp to one clock.

// File: rtl/sensor_readout_pkg.sv
package sensor_readout_pkg;

    // Internal coordinates and counts share one generous width.
    localparam int CW = 16;
    typedef logic [CW-1:0] coord_t;

    typedef enum logic [0:0] {
        PH_ACTIVE = 1'b0,
        PH_VBLANK = 1'b1
    } scan_phase_e;

    // Captured frame settings, already resolved for the selected mode.
    typedef struct packed {
        coord_t line_px;   // pixels per line
        coord_t lines;     // lines per frame
        coord_t col_base;  // array column of first pixel
        coord_t row_base;  // array row of first line
        coord_t hgap;      // horizontal gap, at least 1
        coord_t vgap;      // vertical gap in line periods
    } frame_cfg_t;

    // Scan position inside the frame / blanking sequence.
    typedef struct packed {
        scan_phase_e phase;
        coord_t      h;    // clock within the line period
        coord_t      r;    // line within the frame
        coord_t      vb;   // line period within the vertical gap
    } scan_pos_t;

    // Per-clock request handed to the pixel stage.
    typedef struct packed {
        logic   fv;
        logic   lv;
        coord_t row;
        coord_t col;
    } pix_req_t;

    function automatic coord_t at_least_one(coord_t v);
        return (v == '0) ? coord_t'(1) : v;
    endfunction

    // Pattern word for one array coordinate; border cells give the pedestal.
    function automatic coord_t pixel_code(
        coord_t row, coord_t col,
        coord_t cols, coord_t rows,
        coord_t bl, coord_t bt, coord_t br, coord_t bb,
        coord_t weight, coord_t pedestal);
        logic border;
        border = (col < bl) || (col >= cols - br) ||
                 (row < bt) || (row >= rows - bb);
        return border ? pedestal : (row * weight + col);
    endfunction

endpackage

// File: rtl/sensor_cfg_latch.sv
module sensor_cfg_latch
    import sensor_readout_pkg::*;
#(
    parameter int ARRAY_COLS = 1312,
    parameter int ARRAY_ROWS = 1048,
    parameter int COL_W      = 11,
    parameter int ROW_W      = 11,
    parameter int HB_W       = 12,
    parameter int VB_W       = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             raw_mode,
    input  logic [COL_W-1:0] win_cols,
    input  logic [ROW_W-1:0] win_rows,
    input  logic [COL_W-1:0] col_start,
    input  logic [ROW_W-1:0] row_start,
    input  logic [HB_W-1:0]  hblank,
    input  logic [VB_W-1:0]  vblank,
    output frame_cfg_t       cfg,
    output coord_t           next_line_px
);

    frame_cfg_t cfg_next;

    always_comb begin
        cfg_next.hgap = at_least_one(coord_t'(hblank));
        cfg_next.vgap = coord_t'(vblank);
        if (raw_mode) begin
            cfg_next.line_px  = coord_t'(ARRAY_COLS);
            cfg_next.lines    = coord_t'(ARRAY_ROWS);
            cfg_next.col_base = '0;
            cfg_next.row_base = '0;
        end else begin
            cfg_next.line_px  = at_least_one(coord_t'(win_cols));
            cfg_next.lines    = at_least_one(coord_t'(win_rows));
            cfg_next.col_base = coord_t'(col_start);
            cfg_next.row_base = coord_t'(row_start);
        end
    end

    assign next_line_px = cfg_next.line_px;

    // Capture during reset and at the edge presenting a frame's last pixel.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg <= cfg_next;
        end
    end

endmodule

// File: rtl/sensor_scan_counter.sv
module sensor_scan_counter
    import sensor_readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_cfg_t cfg,
    input  coord_t     next_line_px,
    output logic       frame_end,
    output pix_req_t   req
);

    scan_pos_t pos;
    logic      last_px;
    logic      line_end;

    assign last_px   = (pos.phase == PH_ACTIVE) && (pos.h == cfg.line_px - 16'd1);
    assign line_end  = (pos.h == cfg.line_px + cfg.hgap - 16'd1);
    assign frame_end = last_px && (pos.r == cfg.lines - 16'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos.phase <= PH_ACTIVE;
            pos.h     <= '0;
            pos.r     <= '0;
            pos.vb    <= '0;
        end else begin
            case (pos.phase)
                PH_ACTIVE: begin
                    if (frame_end) begin
                        // Enter the gap at the trailing horizontal blank of the
                        // newly captured line length, so the gap totals
                        // hgap + vgap line periods without a multiplier.
                        pos.phase <= PH_VBLANK;
                        pos.h     <= next_line_px;
                        pos.r     <= '0;
                        pos.vb    <= '0;
                    end else if (line_end) begin
                        pos.h <= '0;
                        pos.r <= pos.r + 16'd1;
                    end else begin
                        pos.h <= pos.h + 16'd1;
                    end
                end
                default: begin
                    if (line_end) begin
                        pos.h <= '0;
                        if (pos.vb == cfg.vgap) begin
                            pos.phase <= PH_ACTIVE;
                            pos.r     <= '0;
                            pos.vb    <= '0;
                        end else begin
                            pos.vb <= pos.vb + 16'd1;
                        end
                    end else begin
                        pos.h <= pos.h + 16'd1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        req.fv  = (pos.phase == PH_ACTIVE);
        req.lv  = req.fv && (pos.h < cfg.line_px);
        req.row = cfg.row_base + pos.r;
        req.col = cfg.col_base + pos.h;
    end

    // R5: the clock counter never leaves the current line period.
    a_r5_h_in_period: assert property (@(posedge clk) disable iff (rst)
        pos.h < cfg.line_px + cfg.hgap);

    // R8: settings hold steady across a frame in progress.
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pos.phase == PH_ACTIVE && $past(pos.phase == PH_ACTIVE))
        |-> $stable(cfg));

endmodule

// File: rtl/sensor_pixel_gen.sv
module sensor_pixel_gen
    import sensor_readout_pkg::*;
#(
    parameter int ARRAY_COLS   = 1312,
    parameter int ARRAY_ROWS   = 1048,
    parameter int BLACK_LEFT   = 16,
    parameter int BLACK_TOP    = 8,
    parameter int BLACK_RIGHT  = 7,
    parameter int BLACK_BOTTOM = 7,
    parameter int ROW_WEIGHT   = 7,
    parameter int PEDESTAL     = 42,
    parameter int DATA_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  pix_req_t          req,
    output logic              fval,
    output logic              lval,
    output logic [DATA_W-1:0] data
);

    coord_t code;

    assign code = pixel_code(req.row, req.col,
                             coord_t'(ARRAY_COLS), coord_t'(ARRAY_ROWS),
                             coord_t'(BLACK_LEFT), coord_t'(BLACK_TOP),
                             coord_t'(BLACK_RIGHT), coord_t'(BLACK_BOTTOM),
                             coord_t'(ROW_WEIGHT), coord_t'(PEDESTAL));

    always_ff @(posedge clk) begin
        if (rst) begin
            fval <= 1'b0;
            lval <= 1'b0;
            data <= '0;
        end else begin
            fval <= req.fv;
            lval <= req.lv;
            data <= req.lv ? DATA_W'(code) : '0;
        end
    end

endmodule

// File: rtl/sensor_readout_gen.sv
module sensor_readout_gen
    import sensor_readout_pkg::*;
#(
    parameter int ARRAY_COLS   = 1312,
    parameter int ARRAY_ROWS   = 1048,
    parameter int BLACK_LEFT   = 16,
    parameter int BLACK_TOP    = 8,
    parameter int BLACK_RIGHT  = 7,
    parameter int BLACK_BOTTOM = 7,
    parameter int ROW_WEIGHT   = 7,
    parameter int PEDESTAL     = 42,
    parameter int DATA_W       = 10,
    parameter int HB_W         = 12,
    parameter int VB_W         = 12,
    localparam int COL_W       = $clog2(ARRAY_COLS + 1),
    localparam int ROW_W       = $clog2(ARRAY_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_mode,
    input  logic [COL_W-1:0]  win_cols,
    input  logic [ROW_W-1:0]  win_rows,
    input  logic [COL_W-1:0]  col_start,
    input  logic [ROW_W-1:0]  row_start,
    input  logic [HB_W-1:0]   hblank,
    input  logic [VB_W-1:0]   vblank,
    output logic              pix_clk,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [DATA_W-1:0] pix_data
);

    frame_cfg_t cfg;
    coord_t     next_line_px;
    logic       frame_end;
    pix_req_t   req;

    sensor_cfg_latch #(
        .ARRAY_COLS(ARRAY_COLS), .ARRAY_ROWS(ARRAY_ROWS),
        .COL_W(COL_W), .ROW_W(ROW_W), .HB_W(HB_W), .VB_W(VB_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(frame_end), .raw_mode(raw_mode),
        .win_cols(win_cols), .win_rows(win_rows),
        .col_start(col_start), .row_start(row_start),
        .hblank(hblank), .vblank(vblank),
        .cfg(cfg), .next_line_px(next_line_px)
    );

    sensor_scan_counter u_scan (
        .clk(clk), .rst(rst), .cfg(cfg), .next_line_px(next_line_px),
        .frame_end(frame_end), .req(req)
    );

    sensor_pixel_gen #(
        .ARRAY_COLS(ARRAY_COLS), .ARRAY_ROWS(ARRAY_ROWS),
        .BLACK_LEFT(BLACK_LEFT), .BLACK_TOP(BLACK_TOP),
        .BLACK_RIGHT(BLACK_RIGHT), .BLACK_BOTTOM(BLACK_BOTTOM),
        .ROW_WEIGHT(ROW_WEIGHT), .PEDESTAL(PEDESTAL), .DATA_W(DATA_W)
    ) u_pix (
        .clk(clk), .rst(rst), .req(req),
        .fval(frame_valid), .lval(line_valid), .data(pix_data)
    );

    // R9: pixel clock runs in phase with the master clock.
    assign pix_clk = clk;

    // R2: a line never shows outside a frame.
    a_r2_line_in_frame: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> frame_valid);

    // R2: every frame opens with a pixel.
    a_r2_frame_opens_with_pixel: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> line_valid);

    // R4: blank clocks carry a zero word.
    a_r4_blank_zero: assert property (@(posedge clk) disable iff (rst)
        !line_valid |-> (pix_data == '0));

    // R1: outputs idle while reset is held.
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!frame_valid && !line_valid));

endmodule

// File: tb/sensor_readout_gen_bench.sv
`timescale 1ns/1ps
module sensor_readout_gen_bench;

    localparam int AC = 12, AR = 10, BL = 3, BT = 2, BR = 2, BB = 1;
    localparam int DW = 10, HBW = 4, VBW = 4;
    localparam int CWB = $clog2(AC + 1);
    localparam int RWB = $clog2(AR + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           raw_mode;
    logic [CWB-1:0] win_cols, col_start;
    logic [RWB-1:0] win_rows, row_start;
    logic [HBW-1:0] hblank;
    logic [VBW-1:0] vblank;
    logic           pix_clk, frame_valid, line_valid;
    logic [DW-1:0]  pix_data;

    int checks = 0;
    int errors = 0;

    int c_raw[6], c_cols[6], c_rows[6], c_cs[6], c_rs[6], c_hb[6], c_vb[6];

    always #4 clk = ~clk;

    sensor_readout_gen #(
        .ARRAY_COLS(AC), .ARRAY_ROWS(AR),
        .BLACK_LEFT(BL), .BLACK_TOP(BT), .BLACK_RIGHT(BR), .BLACK_BOTTOM(BB),
        .ROW_WEIGHT(7), .PEDESTAL(42), .DATA_W(DW), .HB_W(HBW), .VB_W(VBW)
    ) u_sensor_readout_gen (
        .clk(clk), .rst(rst), .raw_mode(raw_mode),
        .win_cols(win_cols), .win_rows(win_rows),
        .col_start(col_start), .row_start(row_start),
        .hblank(hblank), .vblank(vblank),
        .pix_clk(pix_clk), .frame_valid(frame_valid),
        .line_valid(line_valid), .pix_data(pix_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_px(input int row, input int col);
        if (col < BL || col >= AC - BR || row < BT || row >= AR - BB) return 42;
        return (row * 7 + col) % 1024;
    endfunction

    function automatic int eff_hb(input int i);
        return (c_hb[i] == 0) ? 1 : c_hb[i];
    endfunction

    task automatic set_cfg(input int i);
        raw_mode  = c_raw[i][0];
        win_cols  = CWB'(c_cols[i]);
        win_rows  = RWB'(c_rows[i]);
        col_start = CWB'(c_cs[i]);
        row_start = RWB'(c_rs[i]);
        hblank    = HBW'(c_hb[i]);
        vblank    = VBW'(c_vb[i]);
    endtask

    // Entered at the negedge showing the frame's first pixel.
    task automatic run_frame(input int i);
        int px, ln, rb, cb, hb, n, exp_gap, nx;
        string tag;
        px  = c_raw[i] ? AC : c_cols[i];
        ln  = c_raw[i] ? AR : c_rows[i];
        rb  = c_raw[i] ? 0  : c_rs[i];
        cb  = c_raw[i] ? 0  : c_cs[i];
        hb  = eff_hb(i);
        tag = c_raw[i] ? "R7" : "R2/R3";
        for (int r = 0; r < ln; r++) begin
            for (int c = 0; c < px; c++) begin
                check(frame_valid === 1'b1, "R2 frame_valid in frame", int'(frame_valid), 1);
                check(line_valid === 1'b1, "R2 line_valid on pixel", int'(line_valid), 1);
                check(int'(pix_data) == exp_px(rb + r, cb + c), tag,
                      int'(pix_data), exp_px(rb + r, cb + c));
                // R8: new settings arrive mid-frame and must not apply yet.
                if (r == 0 && c == 0) set_cfg(i + 1);
                @(negedge clk);
            end
            if (r < ln - 1) begin
                for (int g = 0; g < hb; g++) begin
                    check(line_valid === 1'b0, "R5 line gap", int'(line_valid), 0);
                    check(frame_valid === 1'b1, "R5 frame held in gap", int'(frame_valid), 1);
                    check(pix_data == '0, "R4 zero in gap", int'(pix_data), 0);
                    @(negedge clk);
                end
            end
        end
        nx = i + 1;
        exp_gap = eff_hb(nx) + c_vb[nx] * ((c_raw[nx] ? AC : c_cols[nx]) + eff_hb(nx));
        n = 0;
        while (frame_valid !== 1'b1 && n < 1000) begin
            check(line_valid === 1'b0 && pix_data == '0, "R4 zero in frame gap",
                  int'(pix_data), 0);
            n++;
            @(negedge clk);
        end
        check(n == exp_gap, "R6/R8 frame gap length", n, exp_gap);
    endtask

    initial begin
        // window mode, full active area
        c_raw[0]=0; c_cols[0]=7; c_rows[0]=7; c_cs[0]=3; c_rs[0]=2; c_hb[0]=2; c_vb[0]=1;
        // small window, minimum blanking
        c_raw[1]=0; c_cols[1]=4; c_rows[1]=3; c_cs[1]=4; c_rs[1]=3; c_hb[1]=1; c_vb[1]=0;
        // raw mode; window fields must be ignored
        c_raw[2]=1; c_cols[2]=2; c_rows[2]=2; c_cs[2]=5; c_rs[2]=5; c_hb[2]=3; c_vb[2]=2;
        // window straddling left and bottom border, hblank 0 clamps to 1
        c_raw[3]=0; c_cols[3]=5; c_rows[3]=2; c_cs[3]=1; c_rs[3]=8; c_hb[3]=0; c_vb[3]=1;
        c_raw[4]=0; c_cols[4]=7; c_rows[4]=7; c_cs[4]=3; c_rs[4]=2; c_hb[4]=4; c_vb[4]=0;
        c_raw[5]=0; c_cols[5]=7; c_rows[5]=7; c_cs[5]=3; c_rs[5]=2; c_hb[5]=4; c_vb[5]=0;
        set_cfg(0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(frame_valid === 1'b0 && line_valid === 1'b0 && pix_data == '0,
              "R1 reset idle", int'(pix_data), 0);
        @(posedge clk); #1;
        check(pix_clk === 1'b1, "R9 pix_clk high", int'(pix_clk), 1);
        @(negedge clk); #1;
        check(pix_clk === 1'b0, "R9 pix_clk low", int'(pix_clk), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(frame_valid === 1'b1, "R1 first frame one clock after reset",
              int'(frame_valid), 1);
        for (int i = 0; i < 5; i++) run_frame(i);
        @(posedge clk); #1;
        check(pix_clk === 1'b1, "R9 pix_clk during run", int'(pix_clk), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule